// File: doc/BRIEF.md
# Parallel Periodic Radon Projection Engine

The engine takes a square image of N by N pixels, with N prime, and computes all N+1 projections of its discrete periodic Radon transform. The whole image is held in on-chip registers. Rows arrive one per accepted beat on a valid/ready input. Each row goes into its own circular register. Row i rotates left by i pixel positions between projections, so a fixed bank of N pipelined column adder trees produces every sum of one projection in the same cycle. For the final projection, the row sums, the trees read a transposed view of the register array. That view costs one cycle and no extra storage.

Results leave as one beat per projection. Each beat is tagged with its projection index and carries N sums of B + ceil(log2 N) bits each, so no sum can overflow. The output has no backpressure, so a consumer must accept a beat in every cycle while `out_valid` is high. The input is refused from the moment the last row is taken until the final projection has been emitted.

Top module: `dprt_engine`

## Requirements
- R1: `in_ready` is high while rows are being collected. It goes low in the cycle after the N-th row is accepted, stays low through the cycle in which `out_last` is high, and is high again in the next cycle.
- R2: Accepted beats fill image rows 0 to N-1 in order, and idle cycles between beats do not disturb the order. In a beat, pixel column j occupies bits [j*B +: B] of `in_row`.
- R3: For projection index m < N, output word d equals the sum over rows i of f(i, (d + m*i) mod N).
- R4: For projection index N, output word d equals the sum over columns j of f(d, j), which is the sum of row d.
- R5: In `out_data`, word d occupies bits [d*OW +: OW], with OW = B + ceil(log2 N). An image with every pixel at its maximum gives exactly N*(2^B-1) in every word, with no wrap.
- R6: Projections come out in consecutive cycles with indices 0, 1, ..., N, starting at 0. `out_last` is high only on the beat with index N.
- R7: Projection m is on the outputs exactly ceil(log2 N) + m cycles after the clock edge that accepts the last row. The whole transform therefore ends within 2N + ceil(log2 N) + 1 cycles of the first row.
- R8: `in_valid` and `in_row` have no effect while `in_ready` is low. The results of the image in progress are unchanged, and so are those of the next image.
- R9: After a synchronous active-low reset, `out_valid` is low and `in_ready` is high. A reset in the middle of a load discards the partly loaded image, and the next image loads from row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An image row is offered |
| in_ready | output | 1 | The engine accepts a row |
| in_row | input | N*B | One image row, column j at bits [j*B +: B] |
| out_valid | output | 1 | A projection beat is present |
| out_index | output | clog2(N+1) | Projection index, 0 to N |
| out_data | output | N*OW | N sums, word d at bits [d*OW +: OW] |
| out_last | output | 1 | Marks the final projection, index N |

## Verification
Every output word is due at a fixed cycle: projection m shows ceil(log2 N) + m edges after the edge that accepts the final row. The bench notes that edge from its own cycle counter. It then checks each output beat on a falling edge, comparing the current count with the expected one, so a beat that is early, late or missing is reported as a timing failure. `in_ready` is sampled on every falling edge while the engine is busy, and once more in the cycle after `out_last`. Junk is driven on the input throughout the busy window, and the results of both the current image and the next one are compared against sums the bench computes itself.

// File: rtl/dprt_pkg.sv
// Shared types of the periodic Radon engine.
// Assumes nothing beyond a synchronous clock domain.
package dprt_pkg;
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } dprt_state_e;
endpackage

// File: rtl/dprt_row.sv
// One image row held in a circular register.
// On load, the row is replaced by a new one. On rotate, the row moves left by
// SHIFT pixel positions, so that new pixel j is old pixel (j+SHIFT) mod N.
// Assumes load and rotate are never both high. Load wins if they are.
module dprt_row #(
    parameter int N     = 5,
    parameter int B     = 8,
    parameter int SHIFT = 0
) (
    input  logic           clk,
    input  logic           load,
    input  logic [N*B-1:0] load_row,
    input  logic           rotate,
    output logic [N*B-1:0] row_q
);
    localparam int S = SHIFT % N;

    logic [N*B-1:0] rotated;

    // Fixed wiring for a left rotation by S pixels.
    always_comb begin
        if (S == 0) rotated = row_q;
        else        rotated = (row_q >> (S*B)) | (row_q << ((N-S)*B));
    end

    // Row storage: load a new row or rotate in place.
    always_ff @(posedge clk) begin
        if (load)        row_q <= load_row;
        else if (rotate) row_q <= rotated;
    end
endmodule

// File: rtl/dprt_tree.sv
// Pipelined adder tree that sums N pixels of B bits into OW bits.
// The inputs are padded with zeros up to a power of two, and there is one
// register level per tree level, so the latency is ceil(log2 N) cycles.
// Assumes N >= 2 and OW >= B + ceil(log2 N).
module dprt_tree #(
    parameter int N  = 5,
    parameter int B  = 8,
    parameter int OW = 11
) (
    input  logic           clk,
    input  logic [N*B-1:0] vec,
    output logic [OW-1:0]  sum
);
    localparam int L  = $clog2(N);
    localparam int W2 = 1 << L;

    for (genvar l = 0; l <= L; l++) begin : g_lvl
        localparam int CNT = W2 >> l;
        logic [OW-1:0] node [CNT];
        if (l == 0) begin : g_leaf
            // Widen the pixels and pad the spare leaves with zero.
            always_comb begin
                for (int j = 0; j < CNT; j++)
                    node[j] = (j < N) ? OW'(vec[j*B +: B]) : '0;
            end
        end else begin : g_add
            // One registered level of pairwise sums.
            always_ff @(posedge clk) begin
                for (int j = 0; j < CNT; j++)
                    node[j] <= g_lvl[l-1].node[2*j] + g_lvl[l-1].node[2*j+1];
            end
        end
    end

    assign sum = g_lvl[L].node[0];
endmodule

// File: rtl/dprt_ctrl.sv
// Sequencer of the engine.
// ST_LOAD collects N rows. ST_RUN feeds projections 0..N to the trees, one per
// cycle, and rotates the rows after each of steps 0..N-1. ST_DRAIN waits for the
// final beat to leave the pipeline.
// Assumes last_out is high for one cycle per image.
module dprt_ctrl
    import dprt_pkg::*;
#(
    parameter int N = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          load_fire,
    output logic [RW-1:0] load_idx,
    output logic          feed_valid,
    output logic [IW-1:0] feed_idx,
    output logic          feed_transpose,
    output logic          rotate,
    input  logic          last_out
);
    localparam int RW = $clog2(N);
    localparam int IW = $clog2(N+1);

    dprt_state_e   state;
    logic [RW-1:0] row_cnt;
    logic [IW-1:0] step;

    // State, row counter and projection step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_LOAD;
            row_cnt <= '0;
            step    <= '0;
        end else begin
            case (state)
                ST_LOAD: if (in_valid) begin
                    if (row_cnt == RW'(N-1)) begin
                        row_cnt <= '0;
                        step    <= '0;
                        state   <= ST_RUN;
                    end else begin
                        row_cnt <= row_cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    step <= step + 1'b1;
                    if (step == IW'(N)) state <= ST_DRAIN;
                end
                ST_DRAIN: if (last_out) state <= ST_LOAD;
                default: state <= ST_LOAD;
            endcase
        end
    end

    // Control strobes decoded from the state.
    always_comb begin
        in_ready       = (state == ST_LOAD);
        load_fire      = in_valid && in_ready;
        load_idx       = row_cnt;
        feed_valid     = (state == ST_RUN);
        feed_idx       = step;
        feed_transpose = (state == ST_RUN) && (step == IW'(N));
        rotate         = (state == ST_RUN) && (step < IW'(N));
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fire && load_idx == RW'(N-1)) |=> !in_ready); // R1
    AST_NO_LOAD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        feed_valid |-> !load_fire); // R8
endmodule

// File: rtl/dprt_engine.sv
// Top of the forward periodic Radon engine.
// It has N row registers with left rotations of 0..N-1 pixels, N column adder
// trees, and a tag pipeline that matches the depth of the trees.
// Assumes N is prime, N >= 2, and that the consumer takes a beat in every
// cycle in which out_valid is high.
module dprt_engine #(
    parameter int N  = 5,
    parameter int B  = 8,
    parameter int L  = $clog2(N),
    parameter int OW = B + L,
    parameter int IW = $clog2(N+1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [N*B-1:0]  in_row,
    output logic            out_valid,
    output logic [IW-1:0]   out_index,
    output logic [N*OW-1:0] out_data,
    output logic            out_last
);
    localparam int RW = $clog2(N);
    localparam logic [OW-1:0] MAXSUM = OW'(N * ((2**B) - 1));

    logic          load_fire, feed_valid, feed_transpose, rotate;
    logic [RW-1:0] load_idx;
    logic [IW-1:0] feed_idx;
    logic [N*B-1:0] rows_q [N];
    logic [N*B-1:0] col_in [N];
    logic [L-1:0]   tag_v;
    logic [IW-1:0]  tag_i [L];

    dprt_ctrl #(.N(N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .load_fire(load_fire), .load_idx(load_idx), .feed_valid(feed_valid),
        .feed_idx(feed_idx), .feed_transpose(feed_transpose), .rotate(rotate),
        .last_out(out_last)
    );

    for (genvar i = 0; i < N; i++) begin : g_row
        dprt_row #(.N(N), .B(B), .SHIFT(i)) u_row (
            .clk(clk), .load(load_fire && load_idx == RW'(i)),
            .load_row(in_row), .rotate(rotate), .row_q(rows_q[i])
        );
    end

    // Each tree reads a column of the array, or a row when the view is transposed.
    always_comb begin
        for (int d = 0; d < N; d++)
            for (int i = 0; i < N; i++)
                col_in[d][i*B +: B] = feed_transpose ? rows_q[d][i*B +: B]
                                                     : rows_q[i][d*B +: B];
    end

    for (genvar d = 0; d < N; d++) begin : g_tree
        dprt_tree #(.N(N), .B(B), .OW(OW)) u_tree (
            .clk(clk), .vec(col_in[d]), .sum(out_data[d*OW +: OW])
        );
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_data[d*OW +: OW] <= MAXSUM); // R5
    end

    // Tag pipeline: valid and projection index travel beside the tree levels.
    always_ff @(posedge clk) begin
        if (!rst_n) tag_v <= '0;
        else begin
            tag_v[0] <= feed_valid;
            for (int s = 1; s < L; s++) tag_v[s] <= tag_v[s-1];
        end
        tag_i[0] <= feed_idx;
        for (int s = 1; s < L; s++) tag_i[s] <= tag_i[s-1];
    end

    assign out_valid = tag_v[L-1];
    assign out_index = tag_i[L-1];
    assign out_last  = out_valid && (out_index == IW'(N));

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R1
    AST_FIRST_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_index == '0); // R6
    AST_INDEX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && out_index == $past(out_index) + 1'b1)); // R6
    AST_LAST_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid); // R6
endmodule

// File: tb/tb_dprt_engine.sv
// Self-checking bench: random and corner images checked against sums computed
// by bench functions, with the timing of every beat checked as well.
module tb_dprt_engine;
    localparam int N      = 5;
    localparam int B      = 8;
    localparam int L      = $clog2(N);
    localparam int OW     = B + L;
    localparam int IW     = $clog2(N+1);
    localparam int PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [N*B-1:0]  in_row = '0;
    logic            out_valid;
    logic [IW-1:0]   out_index;
    logic [N*OW-1:0] out_data;
    logic            out_last;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int img [N][N];

    dprt_engine #(.N(N), .B(B)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_row(in_row), .out_valid(out_valid), .out_index(out_index),
        .out_data(out_data), .out_last(out_last)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int expect_sum(int m, int d);
        int s = 0;
        for (int i = 0; i < N; i++)
            s += (m < N) ? img[i][(d + m*i) % N] : img[d][i];
        return s;
    endfunction

    function automatic logic [N*B-1:0] pack_row(int r);
        logic [N*B-1:0] v;
        for (int j = 0; j < N; j++) v[j*B +: B] = B'(img[r][j]);
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R9 in_ready after reset", in_ready, 1);
    endtask

    // Load one image, with idle gaps if asked, then check every projection beat.
    task automatic run_image(input bit gaps);
        int r = 0;
        int acc = 0;
        int want = 0;
        bit done = 0;
        while (r < N) begin
            @(negedge clk);
            if (gaps && ($urandom % 3 == 0)) begin
                in_valid = 1'b0;
                in_row = N*B'($urandom);
            end else begin
                in_valid = 1'b1;
                in_row = pack_row(r);
                if (in_ready) begin
                    r++;
                    if (r == N) acc = cyc + 1;
                end
            end
        end
        for (int t = 0; t < 4*N + 10 && !done; t++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R1/R8 in_ready low while busy", in_ready, 0);
            in_valid = 1'b1;                    // junk while busy, R8
            in_row = {$urandom, $urandom};
            if (out_valid) begin
                check(out_index == IW'(want), "R6 projection index", out_index, want);
                check(cyc == acc + L + want, "R7 beat timing", cyc, acc + L + want);
                for (int d = 0; d < N; d++)
                    check(out_data[d*OW +: OW] == OW'(expect_sum(want, d)),
                          (want < N) ? "R3 projection sum" : "R4 row-sum projection",
                          out_data[d*OW +: OW], expect_sum(want, d));
                check(out_last == (want == N), "R6 last flag", out_last, want == N);
                if (out_last) begin
                    in_valid = 1'b0;
                    done = 1;
                end
                want++;
            end
        end
        check(done, "R6 final projection seen", done, 1);
        check(want == N + 1, "R6 beat count", want, N + 1);
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready back after last", in_ready, 1);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'h5a17));
        do_reset();
        // Zero image.
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) img[i][j] = 0;
        run_image(0);
        // Maximum image, R5.
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) img[i][j] = (1 << B) - 1;
        run_image(0);
        // Distinct values in each position, with gaps, R2.
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) img[i][j] = i*N + j + 1;
        run_image(1);
        // Reset in the middle of a load, R9.
        @(negedge clk);
        in_valid = 1'b1;
        in_row = {$urandom, $urandom};
        repeat (2) @(negedge clk);
        do_reset();
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) img[i][j] = (i == 2) ? 200 : j;
        run_image(0);
        // Random images.
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) img[i][j] = $urandom % (1 << B);
            run_image(k[0]);
        end
        report();
    end
endmodule